// File: doc/BRIEF.md
# Reload timer with edge-selectable pin request

This block is an 8-bit down-counter that reloads itself from a writable latch. It counts ticks from one of several count sources. When a tick finds the counter at zero, it copies the latch back into the counter and raises an underflow request. A latch value of n therefore divides the chosen source by n+1. Counting halts while the stop input is high. The source can be changed only while the counter is halted; a change attempted while it runs is dropped.

Next to the counter, a count pin passes through a two-stage synchronizer into an edge detector. A polarity input chooses which pin edge sets the pin request. When the measurement mode input is high, both pin edges set the request and the polarity input is ignored. The detector compares the polarity-adjusted pin level with its own previous value. Because of this, flipping the polarity while the pin is still can look like an edge and set the request. Software avoids this by masking the enable, changing the polarity, clearing the request and then unmasking.

Each request stays set until it is cleared, and each interrupt output is its request gated by its enable. Inputs are register-style levels and one-cycle write strobes, all sampled on the rising clock edge.

Top module: `reload_edge_timer`

## Requirements
- R1: After reset the count is 0, both requests are 0 and both interrupt outputs are 0.
- R2: With latch value n (0 to 255), each tick of the selected source while running decrements the count. A tick that finds the count at 0 loads n back in the same cycle and sets the underflow request. After k ticks from a load of n, the count is n - (k mod (n+1)), and the request has been set if k >= n+1.
- R3: A latch write while stopped also loads the count, which is visible one cycle later. A latch write while running changes only the latch, and the new value is used at the next reload.
- R4: While stop is 1, source ticks leave the count and the underflow request unchanged.
- R5: With measurement mode 0 and polarity 0, a falling pin edge sets the pin request, and a rising edge does not.
- R6: With measurement mode 0 and polarity 1, a rising pin edge sets the pin request, and a falling edge does not.
- R7: With measurement mode 1, both rising and falling pin edges set the pin request, whatever the polarity.
- R8: Toggling the polarity while the pin is still sets the pin request when the new polarity treats the present pin level as its active side. Example: pin at 0 and polarity changed from 1 to 0. The request is visible the cycle after the change.
- R9: A source-select write is accepted only while stop is 1. A write while running is ignored, and the previous source keeps driving the count. Source index i selects bit i of the tick input.
- R10: Each interrupt output equals its request ANDed with its enable.
- R11: A request stays set until its clear strobe is high. If a clear arrives in the same cycle as a new event, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | NUM_SRC | One-cycle tick pulses of each count source |
| stop_cnt | input | 1 | 1 halts counting and allows a source change |
| src_sel_we | input | 1 | Write strobe for the source select |
| src_sel_data | input | clog2(NUM_SRC) | Source index to write |
| latch_we | input | 1 | Write strobe for the reload latch |
| latch_data | input | CNT_W | Reload value n |
| pin_in | input | 1 | Asynchronous count pin |
| edge_pol | input | 1 | 0 selects falling edges, 1 selects rising edges |
| meas_mode | input | 1 | 1 selects both edges (pulse-width measurement) |
| uf_ie | input | 1 | Underflow interrupt enable |
| pin_ie | input | 1 | Pin interrupt enable |
| uf_clr | input | 1 | Clear strobe for the underflow request |
| pin_clr | input | 1 | Clear strobe for the pin request |
| count_o | output | CNT_W | Present counter value |
| uf_req | output | 1 | Underflow request flag |
| pin_req | output | 1 | Pin request flag |
| uf_irq | output | 1 | Underflow interrupt |
| pin_irq | output | 1 | Pin interrupt |

## Verification
The hardest case to reach is the false pin request. It needs the pin held still across a polarity change, with the synchronizer already settled so that no real edge is in flight. The stimulus waits several cycles after each pin move before touching the polarity, and it checks the request on both sides of the change. A second hard case is a clear that lands in the same cycle as an event. This is produced with a latch value of 0 on the every-cycle source, so every tick underflows, and the clear is pulsed while counting.

// File: rtl/reload_edge_timer_pkg.sv
package reload_edge_timer_pkg;

    typedef enum logic [0:0] {
        REQ_UF  = 1'b0,
        REQ_PIN = 1'b1
    } req_id_e;

    localparam int NUM_REQ = 2;

    typedef struct packed {
        logic meas;
        logic pol;
    } pin_cfg_t;

    // Pin level seen through the polarity: a rise of this view is the active edge.
    function automatic logic active_view(input logic lvl, input logic pol);
        return lvl ^ ~pol;
    endfunction

endpackage

// File: rtl/ret_src_mux.sv
module ret_src_mux #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               stop_cnt,
    input  logic               sel_we,
    input  logic [SEL_W-1:0]   sel_data,
    output logic               tick
);
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_we && stop_cnt) begin
            sel_q <= sel_data;
        end
    end

    assign tick = src_tick[sel_q] & ~stop_cnt;

    // R9: the selection cannot move while counting runs
    p_sel_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !stop_cnt |=> sel_q == $past(sel_q));

    // R4: no tick escapes while halted
    p_no_tick_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        stop_cnt |-> !tick);

endmodule

// File: rtl/ret_counter.sv
module ret_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             stop_cnt,
    input  logic             latch_we,
    input  logic [CNT_W-1:0] latch_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic             uf_evt
);
    logic [CNT_W-1:0] latch_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign uf_evt  = tick & at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            cnt_q   <= '0;
        end else begin
            if (latch_we) begin
                latch_q <= latch_data;
            end
            if (tick) begin
                cnt_q <= at_zero ? latch_q : cnt_q - 1'b1;
            end else if (latch_we && stop_cnt) begin
                cnt_q <= latch_data;
            end
        end
    end

    // R2: an underflow tick reloads from the latch held before that edge
    p_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == '0) |=> cnt_q == $past(latch_q));

    // R2: a non-zero count steps down by one per tick
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R4: without tick or stopped load the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(latch_we && stop_cnt)) |=> $stable(cnt_q));

endmodule

// File: rtl/ret_pin_edge.sv
module ret_pin_edge
    import reload_edge_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_in,
    input  pin_cfg_t cfg,
    output logic     edge_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   view;
    logic                   view_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
        end
    end

    assign lvl  = sync_q[SYNC_STAGES-1];
    assign view = active_view(lvl, cfg.pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            view_q <= active_view(1'b0, cfg.pol);
        end else begin
            view_q <= view;
        end
    end

    assign edge_evt = cfg.meas ? (view ^ view_q) : (view & ~view_q);

    // R7: in measurement mode any synchronized pin change is an event
    p_both_edges_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.meas && cfg.pol == $past(cfg.pol) && lvl != $past(lvl)) |-> edge_evt);

    // R5: a still pin under a steady polarity raises nothing
    p_still_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.pol == $past(cfg.pol) && lvl == $past(lvl)) |-> !edge_evt);

endmodule

// File: rtl/ret_req_flag.sv
module ret_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr,
    input  logic ie,
    output logic req,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (set_evt) begin
            req <= 1'b1;
        end else if (clr) begin
            req <= 1'b0;
        end
    end

    assign irq = req & ie;

    // R11: an event wins over a coincident clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> req);

    // R11: the flag is sticky without a clear
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (req && !clr) |=> req);

endmodule

// File: rtl/reload_edge_timer.sv
module reload_edge_timer
    import reload_edge_timer_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_tick,
    input  logic                       stop_cnt,
    input  logic                       src_sel_we,
    input  logic [$clog2(NUM_SRC)-1:0] src_sel_data,
    input  logic                       latch_we,
    input  logic [CNT_W-1:0]           latch_data,
    input  logic                       pin_in,
    input  logic                       edge_pol,
    input  logic                       meas_mode,
    input  logic                       uf_ie,
    input  logic                       pin_ie,
    input  logic                       uf_clr,
    input  logic                       pin_clr,
    output logic [CNT_W-1:0]           count_o,
    output logic                       uf_req,
    output logic                       pin_req,
    output logic                       uf_irq,
    output logic                       pin_irq
);
    logic               tick;
    logic               uf_evt;
    logic               pin_evt;
    pin_cfg_t           cfg;
    logic [NUM_REQ-1:0] evt_v, clr_v, ie_v, req_v, irq_v;

    ret_src_mux #(.NUM_SRC(NUM_SRC)) u_src (
        .clk(clk), .rst(rst), .src_tick(src_tick), .stop_cnt(stop_cnt),
        .sel_we(src_sel_we), .sel_data(src_sel_data), .tick(tick)
    );

    ret_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .stop_cnt(stop_cnt),
        .latch_we(latch_we), .latch_data(latch_data),
        .cnt_q(count_o), .uf_evt(uf_evt)
    );

    assign cfg = '{meas: meas_mode, pol: edge_pol};

    ret_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg(cfg), .edge_evt(pin_evt)
    );

    assign evt_v[REQ_UF]  = uf_evt;
    assign evt_v[REQ_PIN] = pin_evt;
    assign clr_v[REQ_UF]  = uf_clr;
    assign clr_v[REQ_PIN] = pin_clr;
    assign ie_v[REQ_UF]   = uf_ie;
    assign ie_v[REQ_PIN]  = pin_ie;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        ret_req_flag u_flag (
            .clk(clk), .rst(rst), .set_evt(evt_v[g]), .clr(clr_v[g]),
            .ie(ie_v[g]), .req(req_v[g]), .irq(irq_v[g])
        );
    end

    assign uf_req  = req_v[REQ_UF];
    assign pin_req = req_v[REQ_PIN];
    assign uf_irq  = irq_v[REQ_UF];
    assign pin_irq = irq_v[REQ_PIN];

    // R10: no interrupt without its enable
    p_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !$countones({uf_irq & ~uf_ie, pin_irq & ~pin_ie}));

endmodule

// File: tb/tb_reload_edge_timer.sv
module tb_reload_edge_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] src_tick;
    logic       stop_cnt, src_sel_we, latch_we, pin_in, edge_pol, meas_mode;
    logic [1:0] src_sel_data;
    logic [7:0] latch_data;
    logic       uf_ie, pin_ie, uf_clr, pin_clr;
    logic [7:0] count_o;
    logic       uf_req, pin_req, uf_irq, pin_irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int phase = 0;

    always #2.5 clk = ~clk;

    reload_edge_timer dut (
        .clk(clk), .rst(rst), .src_tick(src_tick), .stop_cnt(stop_cnt),
        .src_sel_we(src_sel_we), .src_sel_data(src_sel_data),
        .latch_we(latch_we), .latch_data(latch_data), .pin_in(pin_in),
        .edge_pol(edge_pol), .meas_mode(meas_mode), .uf_ie(uf_ie),
        .pin_ie(pin_ie), .uf_clr(uf_clr), .pin_clr(pin_clr),
        .count_o(count_o), .uf_req(uf_req), .pin_req(pin_req),
        .uf_irq(uf_irq), .pin_irq(pin_irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // drive periodic ticks: source i fires every (i+1) cycles; return ticks of src counted
    task automatic run(input int src, input int cycles, output int k);
        k = 0;
        for (int c = 0; c < cycles; c++) begin
            for (int i = 0; i < 4; i++) src_tick[i] = ((phase % (i + 1)) == 0);
            phase++;
            if (src_tick[src] && !stop_cnt) k++;
            step();
        end
        src_tick = '0;
    endtask

    task automatic load_latch(input int n);
        latch_data = 8'(n);
        latch_we   = 1'b1;
        step();
        latch_we   = 1'b0;
    endtask

    task automatic pick_src(input int s);
        src_sel_data = 2'(s);
        src_sel_we   = 1'b1;
        step();
        src_sel_we   = 1'b0;
    endtask

    task automatic clear_uf();
        uf_clr = 1'b1;
        step();
        uf_clr = 1'b0;
    endtask

    task automatic clear_pin();
        pin_clr = 1'b1;
        step();
        pin_clr = 1'b0;
    endtask

    initial begin
        int k;
        int nlist [7] = '{0, 1, 2, 3, 5, 7, 255};
        rst = 1'b1; src_tick = '0; stop_cnt = 1'b1; src_sel_we = 1'b0;
        src_sel_data = '0; latch_we = 1'b0; latch_data = '0; pin_in = 1'b0;
        edge_pol = 1'b0; meas_mode = 1'b0; uf_ie = 1'b0; pin_ie = 1'b0;
        uf_clr = 1'b0; pin_clr = 1'b0;
        idle(4);
        rst = 1'b0;
        step();
        chk("R1 count", count_o, 0);
        chk("R1 uf_req", uf_req, 0);
        chk("R1 pin_req", pin_req, 0);
        chk("R1 irqs", {uf_irq, pin_irq}, 0);

        // R2 / R3 / R9: sweep over sources and latch values
        foreach (nlist[j]) begin
            for (int s = 0; s < 4; s++) begin
                int n = nlist[j];
                stop_cnt = 1'b1;
                pick_src(s);
                load_latch(n);
                chk($sformatf("R3 stopped load n=%0d", n), count_o, n);
                clear_uf();
                stop_cnt = 1'b0;
                run(s, 2 * (n + 1) * (s + 1) + 3 * s + 1, k);
                stop_cnt = 1'b1;
                step();
                chk($sformatf("R2 count n=%0d s=%0d", n, s), count_o, n - (k % (n + 1)));
                chk($sformatf("R2 uf_req n=%0d s=%0d", n, s), uf_req, (k >= n + 1) ? 1 : 0);
            end
        end

        // R4: halted counter ignores ticks
        load_latch(4);
        clear_uf();
        run(0, 20, k);
        chk("R4 count held", count_o, 4);
        chk("R4 uf_req held", uf_req, 0);

        // R9: select write while running is ignored
        pick_src(0);
        load_latch(50);
        stop_cnt = 1'b0;
        src_sel_data = 2'd3; src_sel_we = 1'b1;
        run(0, 1, k);
        src_sel_we = 1'b0;
        begin
            int k2;
            run(0, 11, k2);
            stop_cnt = 1'b1;
            step();
            chk("R9 ignored select", count_o, 50 - (k + k2));
        end

        // R3: latch write while running affects next reload only
        load_latch(3);
        stop_cnt = 1'b0;
        latch_data = 8'd9; latch_we = 1'b1;
        run(0, 1, k);
        latch_we = 1'b0;
        chk("R3 running write keeps count", count_o, 2);
        run(0, 2, k);
        chk("R3 count reaches 0", count_o, 0);
        run(0, 1, k);
        chk("R3 reload uses new latch", count_o, 9);
        stop_cnt = 1'b1;
        step();

        // R10 / R11 on the underflow request
        uf_ie = 1'b0;
        chk("R10 uf gated off", uf_irq, 0);
        uf_ie = 1'b1;
        step();
        chk("R10 uf gated on", uf_irq, uf_req);
        chk("R11 uf sticky", uf_req, 1);
        load_latch(0);
        stop_cnt = 1'b0;
        uf_clr = 1'b1;
        run(0, 1, k);
        uf_clr = 1'b0;
        stop_cnt = 1'b1;
        step();
        chk("R11 clear with event keeps set", uf_req, 1);
        idle(5);
        chk("R11 still set", uf_req, 1);
        clear_uf();
        chk("R11 cleared", uf_req, 0);
        chk("R10 irq drops", uf_irq, 0);
        uf_ie = 1'b0;

        // R5: polarity 0, falling edge
        edge_pol = 1'b0; meas_mode = 1'b0;
        idle(4); clear_pin();
        pin_in = 1'b1; idle(4);
        chk("R5 rising ignored", pin_req, 0);
        pin_in = 1'b0; idle(4);
        chk("R5 falling sets", pin_req, 1);
        clear_pin();

        // R8: pin still at 0, polarity 0 -> 1 quiet, then 1 -> 0 spurious
        edge_pol = 1'b1; idle(2);
        chk("R8 pol to 1 at low pin quiet", pin_req, 0);

        // R6: polarity 1, rising edge
        pin_in = 1'b1; idle(4);
        chk("R6 rising sets", pin_req, 1);
        clear_pin();
        pin_in = 1'b0; idle(4);
        chk("R6 falling ignored", pin_req, 0);

        edge_pol = 1'b0; step();
        chk("R8 pol to 0 at low pin sets", pin_req, 1);
        chk("R10 pin masked", pin_irq, 0);
        clear_pin();
        pin_ie = 1'b1; step();
        chk("R10 pin enabled after clear", pin_irq, 0);

        // R7: measurement mode, both edges with either polarity
        meas_mode = 1'b1;
        for (int p = 0; p < 2; p++) begin
            edge_pol = p[0];
            idle(3); clear_pin();
            pin_in = 1'b1; idle(4);
            chk($sformatf("R7 rise pol=%0d", p), pin_req, 1);
            chk($sformatf("R10 pin irq pol=%0d", p), pin_irq, 1);
            clear_pin();
            pin_in = 1'b0; idle(4);
            chk($sformatf("R7 fall pol=%0d", p), pin_req, 1);
            clear_pin();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule